// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device end of a small serial EEPROM that holds 64 words of 16 bits. A host talks to it over chip select, a serial clock, one data line into the device and one data line out. Each transaction opens with a rise of chip select and is followed by a start bit, a two-bit opcode and a six-bit address. The host can read a word, program or erase one word, or program or erase every word at once. It can also switch a programming-enable latch on or off. The serial pins are sampled on a system clock. Rising edges of the serial clock are found by comparing each sample with the one before it.

When a programming command is accepted, the word or the whole array is updated and a busy window starts. The window lasts a set number of system clocks, given by a parameter. If the host drops chip select and raises it again during that window, data out shows the ready/busy level. The output-enable pin models the tri-state driver and is active only while chip select is high.

Top module: `serial_eeprom_dev`

## Requirements
- R1: After reset the enable latch is clear and every word reads 0000h. `ser_out_en` is high exactly while `chip_sel` is high.
- R2: An instruction is framed only after a rise of `chip_sel`. Zeros clocked before the start bit (1) are skipped. Bits clocked after an instruction has completed, within the same select, are ignored.
- R3: The two opcode bits select the instruction: 10 read, 01 write, 11 erase, 00 extended. The six address bits follow, MSB first.
- R4: A read drives 0 on `ser_out` at the serial clock rise that carries the last address bit. It then gives the 16 data bits MSB first, one per following rise. A read works whether the latch is set or clear.
- R5: In an extended command the two MSBs of the address field pick the action: 11 sets the latch and 00 clears it. The latch keeps its value across selects until a clear command or reset.
- R6: A write takes 16 data bits, MSB first, after the address. On the last of these bits, with the latch set, the word is stored and a busy window starts.
- R7: Erase (opcode 11) sets the addressed word to FFFFh. Extended selector 10 sets every word to FFFFh.
- R8: Extended selector 01 takes 16 data bits and stores that pattern in every word.
- R9: Write, erase, erase-all and write-all issued while the latch is clear leave memory unchanged.
- R10: The busy window lasts PROG_CYCLES system clocks. If `chip_sel` is raised again during the window, `ser_out` reads 0 while busy and changes to 1 when the window ends, while select stays high.
- R11: If `chip_sel` is raised only after the busy window has ended, no status is shown: `ser_out` is 0 and instruction framing works as usual.
- R12: A select that begins during the busy window decodes no instruction, so bits clocked in it do not change memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_sel | input | 1 | Chip select, high to select |
| ser_clk | input | 1 | Serial clock; its rising edges shift data |
| ser_in | input | 1 | Serial data into the device |
| ser_out | output | 1 | Serial data out: read data or ready/busy level |
| ser_out_en | output | 1 | Output enable modelling the tri-state driver |

## Verification
The hardest case to reach is a select that starts while the busy window is still running. The host must finish a programming frame, drop chip select and raise it again within PROG_CYCLES clocks, and only then clock bits in. The bench does this by timing its select tasks so the re-raise falls a few clocks after the last data bit. It then sends a complete write frame in the status-mode select and reads the target word back once the window has closed. The opposite case, a re-raise only after the window has ended, is handled by waiting past the window before selecting. In that select the bench then runs a full read.

// File: rtl/eep_pkg.sv
// Package: shared encodings for the serial EEPROM device model.
// Assumes: opcode and extended-selector values are fixed by the serial protocol.
package eep_pkg;
    typedef enum logic [2:0] {
        FS_IDLE, FS_START, FS_OP, FS_ADDR, FS_DATA, FS_READ, FS_STAT, FS_DONE
    } frame_state_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] XS_LOCK   = 2'b00;
    localparam logic [1:0] XS_FILL   = 2'b01;
    localparam logic [1:0] XS_CLEAR  = 2'b10;
    localparam logic [1:0] XS_UNLOCK = 2'b11;
endpackage

// File: rtl/eep_store.sv
// Module: word array with a single write port able to update one word or all words.
// Assumes: wr_en is a one-cycle pulse and rd_addr is read combinationally.
module eep_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Update this word on a broadcast write or a matching single write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && (wr_all || wr_addr == ADDR_W'(g)))
                mem[g] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    a_r6_word_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

    a_r8_all_words_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_all) |=> (mem[0] == $past(wr_data) && mem[WORDS-1] == $past(wr_data)));
endmodule

// File: rtl/eep_busy_timer.sv
// Module: self-timed programming window, PROG_CYCLES clocks long.
// Assumes: go is a one-cycle pulse never raised while busy.
module eep_busy_timer #(
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Load the window length on go, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (go)
            remain <= CNT_W'(PROG_CYCLES);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    a_r10_go_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    a_r10_busy_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (!busy || $past(go)));
endmodule

// File: rtl/eep_frame.sv
// Module: serial instruction framer and decoder with the programming-enable latch.
// Assumes: chip_sel, ser_clk and ser_in are steady for at least one clk around each
// change, and a serial clock rise needs at least two clk periods between rises.
module eep_frame
    import eep_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel,
    input  logic              ser_clk,
    input  logic              ser_in,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic              prog_go,
    output logic              prog_all,
    output logic [DATA_W-1:0] prog_data,
    output logic              stat_mode,
    output logic              dout_q
);
    localparam int CNT_W = $clog2(DATA_W);

    frame_state_e      state;
    logic              cs_q, sk_q, wen, rd_load;
    logic [1:0]        opc;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg, rd_sr;
    logic [ADDR_W-1:0] full_addr;
    logic              sk_rise;

    assign sk_rise   = ser_clk && !sk_q;
    assign full_addr = {addr_q[ADDR_W-2:0], ser_in};
    assign stat_mode = (state == FS_STAT);

    // Frame bits on serial clock rises, decode, and issue programming pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_IDLE;   cs_q <= 1'b0;   sk_q <= 1'b0;  wen <= 1'b0;
            rd_load <= 1'b0;    opc <= '0;      cnt <= '0;     shreg <= '0;
            rd_sr <= '0;        addr_q <= '0;   prog_go <= 1'b0;
            prog_all <= 1'b0;   prog_data <= '0; dout_q <= 1'b0;
        end else begin
            cs_q    <= chip_sel;
            sk_q    <= ser_clk;
            prog_go <= 1'b0;
            rd_load <= 1'b0;
            if (rd_load)
                rd_sr <= rd_data;
            if (!chip_sel) begin
                state  <= FS_IDLE;
                dout_q <= 1'b0;
            end else if (!cs_q) begin
                state <= busy ? FS_STAT : FS_START;
            end else if (sk_rise) begin
                case (state)
                    FS_START: if (ser_in) begin
                        state <= FS_OP;
                        cnt   <= '0;
                    end
                    FS_OP: begin
                        opc <= {opc[0], ser_in};
                        if (cnt == CNT_W'(1)) begin
                            state <= FS_ADDR;
                            cnt   <= '0;
                        end else
                            cnt <= cnt + 1'b1;
                    end
                    FS_ADDR: begin
                        addr_q <= full_addr;
                        if (cnt == CNT_W'(ADDR_W - 1)) begin
                            cnt   <= '0;
                            state <= FS_DONE;
                            case (opc)
                                OPC_READ: begin
                                    state   <= FS_READ;
                                    dout_q  <= 1'b0;
                                    rd_load <= 1'b1;
                                end
                                OPC_WRITE: begin
                                    state    <= FS_DATA;
                                    prog_all <= 1'b0;
                                end
                                OPC_ERASE: begin
                                    prog_go   <= wen;
                                    prog_all  <= 1'b0;
                                    prog_data <= '1;
                                end
                                default: begin
                                    case (full_addr[ADDR_W-1 -: 2])
                                        XS_UNLOCK: wen <= 1'b1;
                                        XS_LOCK:   wen <= 1'b0;
                                        XS_CLEAR: begin
                                            prog_go   <= wen;
                                            prog_all  <= 1'b1;
                                            prog_data <= '1;
                                        end
                                        default: begin
                                            state    <= FS_DATA;
                                            prog_all <= 1'b1;
                                        end
                                    endcase
                                end
                            endcase
                        end else
                            cnt <= cnt + 1'b1;
                    end
                    FS_DATA: begin
                        shreg <= {shreg[DATA_W-2:0], ser_in};
                        if (cnt == CNT_W'(DATA_W - 1)) begin
                            prog_go   <= wen;
                            prog_data <= {shreg[DATA_W-2:0], ser_in};
                            state     <= FS_DONE;
                        end else
                            cnt <= cnt + 1'b1;
                    end
                    FS_READ: begin
                        dout_q <= rd_sr[DATA_W-1];
                        rd_sr  <= {rd_sr[DATA_W-2:0], 1'b0};
                        if (cnt == CNT_W'(DATA_W - 1))
                            state <= FS_DONE;
                        else
                            cnt <= cnt + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r9_prog_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> wen);

    a_r12_no_prog_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !prog_go);

    a_r4_dummy_bit_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_READ && $past(state) != FS_READ) |-> !dout_q);

    a_r2_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(chip_sel) |-> (state == FS_IDLE || state == FS_START || state == FS_STAT));
endmodule

// File: rtl/serial_eeprom_dev.sv
// Module: top of the serial EEPROM device model; joins framer, array and busy timer.
// Assumes: pins are sampled on clk; ser_out_en models the tri-state output buffer.
module serial_eeprom_dev #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chip_sel,
    input  logic ser_clk,
    input  logic ser_in,
    output logic ser_out,
    output logic ser_out_en
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rd_data, prog_data;
    logic              prog_go, prog_all, stat_mode, dout_q, busy;

    eep_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .ser_clk(ser_clk),
        .ser_in(ser_in), .busy(busy), .rd_data(rd_data), .addr_q(addr_q),
        .prog_go(prog_go), .prog_all(prog_all), .prog_data(prog_data),
        .stat_mode(stat_mode), .dout_q(dout_q)
    );

    eep_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(prog_go), .wr_all(prog_all),
        .wr_addr(addr_q), .wr_data(prog_data), .rd_addr(addr_q), .rd_data(rd_data)
    );

    eep_busy_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(prog_go), .busy(busy)
    );

    // Status level in a select opened while busy, otherwise shifted read data.
    always_comb begin
        ser_out    = stat_mode ? !busy : dout_q;
        ser_out_en = chip_sel;
    end
endmodule

// File: tb/sim_serial_eeprom_dev.sv
module sim_serial_eeprom_dev;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int PC = 40;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, dout_oe;
    int   checks = 0, errors = 0;
    logic [DW-1:0] model [64];
    bit   model_wen;

    serial_eeprom_dev #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .chip_sel(cs), .ser_clk(sk), .ser_in(di),
        .ser_out(dout), .ser_out_en(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        @(negedge clk); di = b; sk = 1'b0;
        @(negedge clk); sk = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic sel_on();
        @(negedge clk); sk = 1'b0; cs = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic sel_off();
        @(negedge clk); sk = 1'b0; cs = 1'b0; di = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic hdr(input logic [1:0] op, input logic [5:0] a);
        pulse(1'b1); send(32'(op), 2); send(32'(a), 6);
    endtask

    // Read a word, checking the dummy bit and the data against the model.
    task automatic rd_chk(input logic [5:0] a, input string req);
        logic [DW-1:0] w = '0;
        sel_on();
        chk("R1 oe while selected", 32'(dout_oe), 32'd1);
        hdr(2'b10, a);
        chk("R4 dummy bit", 32'(dout), 32'd0);
        for (int i = 0; i < DW; i++) begin
            pulse(1'b0);
            w = {w[DW-2:0], dout};
        end
        chk(req, 32'(w), 32'(model[a]));
        sel_off();
        chk("R1 oe when deselected", 32'(dout_oe), 32'd0);
    endtask

    // Close a programming frame; poll ready/busy if the model expects a cycle.
    task automatic finish_prog(input bit started);
        sel_off();
        if (started) begin
            sel_on();
            chk("R10 busy level", 32'(dout), 32'd0);
            repeat (PC) @(negedge clk);
            chk("R10 ready level", 32'(dout), 32'd1);
            sel_off();
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
        bit ok = model_wen;
        sel_on(); hdr(2'b01, a); send(32'(d), DW);
        if (ok) model[a] = d;
        finish_prog(ok);
    endtask

    task automatic er(input logic [5:0] a);
        bit ok = model_wen;
        sel_on(); hdr(2'b11, a);
        if (ok) model[a] = '1;
        finish_prog(ok);
    endtask

    task automatic ext(input logic [1:0] xs, input logic [DW-1:0] pat);
        bit ok = model_wen;
        sel_on(); hdr(2'b00, {xs, 4'b0101});
        case (xs)
            2'b11: begin model_wen = 1'b1; sel_off(); end
            2'b00: begin model_wen = 1'b0; sel_off(); end
            2'b10: begin
                if (ok) for (int i = 0; i < 64; i++) model[i] = '1;
                finish_prog(ok);
            end
            default: begin
                send(32'(pat), DW);
                if (ok) for (int i = 0; i < 64; i++) model[i] = pat;
                finish_prog(ok);
            end
        endcase
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) model[i] = '0;
        model_wen = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe after reset", 32'(dout_oe), 32'd0);
        rd_chk(6'd0, "R1 word 0 after reset");
        rd_chk(6'd63, "R1 word 63 after reset");
        // R9 programming with latch clear
        wr(6'd5, 16'hBEEF);
        rd_chk(6'd5, "R9 write ignored when locked");
        er(6'd5);
        ext(2'b10, 16'h0);
        rd_chk(6'd5, "R9 erase and erase-all ignored when locked");
        ext(2'b01, 16'h7777);
        rd_chk(6'd7, "R9 write-all ignored when locked");
        // R5 enable, R6 write, R3 address order
        ext(2'b11, 16'h0);
        wr(6'd5, 16'hA5C3);
        rd_chk(6'd5, "R6 written word");
        wr(6'd32, 16'h8001);
        rd_chk(6'd32, "R3 address MSB first");
        rd_chk(6'd1, "R3 neighbour untouched");
        ext(2'b00, 16'h0);
        rd_chk(6'd5, "R4 read while locked");
        wr(6'd5, 16'h1111);
        rd_chk(6'd5, "R5 lock blocks write");
        ext(2'b11, 16'h0);
        wr(6'd6, 16'h0F0F);
        rd_chk(6'd6, "R5 latch sticky across selects");
        // R2 leading zeros before the start bit
        sel_on(); pulse(1'b0); pulse(1'b0); pulse(1'b0);
        hdr(2'b01, 6'd9); send(32'h3C3C, DW); model[9] = 16'h3C3C;
        finish_prog(1'b1);
        rd_chk(6'd9, "R2 leading zeros skipped");
        // R2 second instruction in same select ignored
        sel_on(); hdr(2'b00, 6'b000000);
        hdr(2'b00, 6'b110000);
        sel_off(); model_wen = 1'b0;
        wr(6'd10, 16'h5555);
        rd_chk(6'd10, "R2 trailing instruction ignored");
        ext(2'b11, 16'h0);
        // R11 no status after the window has ended
        sel_on(); hdr(2'b01, 6'd11); send(32'hC001, DW); model[11] = 16'hC001;
        sel_off();
        repeat (PC + 10) @(negedge clk);
        sel_on();
        chk("R11 no status after window", 32'(dout), 32'd0);
        begin
            logic [DW-1:0] w = '0;
            hdr(2'b10, 6'd11);
            for (int i = 0; i < DW; i++) begin pulse(1'b0); w = {w[DW-2:0], dout}; end
            chk("R11 framing normal after window", 32'(w), 32'hC001);
        end
        sel_off();
        // R12 select opened during busy decodes nothing
        sel_on(); hdr(2'b01, 6'd12); send(32'h1234, DW); model[12] = 16'h1234;
        sel_off(); sel_on();
        chk("R12 status shown", 32'(dout), 32'd0);
        hdr(2'b01, 6'd13); send(32'hFFFF, DW);
        chk("R10 ready held while selected", 32'(dout), 32'd1);
        sel_off();
        rd_chk(6'd13, "R12 frame in busy select ignored");
        rd_chk(6'd12, "R6 word stored before status select");
        // R7 erase, erase-all; R8 write-all
        er(6'd5);
        rd_chk(6'd5, "R7 erase word");
        ext(2'b10, 16'h0);
        rd_chk(6'd0, "R7 erase-all word 0");
        rd_chk(6'd40, "R7 erase-all word 40");
        ext(2'b01, 16'h3C5A);
        rd_chk(6'd2, "R8 write-all word 2");
        rd_chk(6'd63, "R8 write-all word 63");
        // Random mix against the model
        for (int n = 0; n < 40; n++) begin
            logic [5:0] a = 6'($urandom_range(0, 63));
            case ($urandom_range(0, 5))
                0, 1: rd_chk(a, "R4 random read");
                2: wr(a, 16'($urandom));
                3: er(a);
                4: ext(2'b11, 16'h0);
                default: ext(2'b00, 16'h0);
            endcase
        end
        rd_chk(6'd5, "R6 final read");
        summary();
    end
endmodule